// File: doc/BRIEF.md
# Programmable Framed Serial Port

This block is a synchronous serial engine with four pins: serial data out, serial data in, serial clock and frame. A programmable divider turns the system clock into a slower base tick. A write to the data port starts a base counter, which advances once per base tick. When that counter reaches a programmed start count, a word of 1 to 16 bits goes out MSB first, and the same number of input bits is taken in.

Each bit takes two base ticks. In the first tick the serial clock is low and the output bit is presented. In the second tick the serial clock is high, and the input is captured as it rises. The frame pin is active while the base counter lies between a programmed turn-on count and a programmed turn-off count. Its active level is programmable. The last serial clock pulse of a word can be suppressed. When a transfer ends, the received word is latched, busy drops and a one-cycle done strobe fires.

Top module: `fsp_top`

## Requirements
- R1: After reset, busy, done, sck and sdo are 0, rx_word is 0, and frm is 1. The reset configuration has polarity 0, so frm sits at its inactive-high level.
- R2: A transfer holds busy high for exactly (S + 2N) * D system cycles after the data write. S is the start count, N is the word length and D is the effective divisor. In the first cycle after that, done is 1 and busy is 0. done is 0 again one cycle later.
- R3: The divisor field ctl_wdata[37:30] gives D. A value of 0 gives the same timing as a value of 1.
- R4: sck is low whenever the block is idle and during the start delay. It then gives one high pulse per bit, and each pulse is D cycles high after D cycles low.
- R5: sdo carries the N-bit word MSB first. Bit i is valid from base count S + 2i, and it stays steady for both halves of its bit period.
- R6: sdi is sampled as sck rises. When the transfer completes, rx_word holds the N sampled bits, right-aligned, with zeros above them.
- R7: The length field ctl_wdata[5:2] holds N - 1, so word sizes from 1 to 16 are supported.
- R8: The frame is active while busy and while the base count is at least the value in ctl_wdata[21:14] and below the value in ctl_wdata[13:6]. Bit ctl_wdata[1] = 1 makes the frame active-high; 0 makes it active-low.
- R9: When ctl_wdata[0] = 1, the final sck pulse is suppressed. The transfer length and data timing do not change.
- R10: While busy, control writes and data writes are ignored. The start count is ctl_wdata[29:22].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 38 | Control value: divisor, start, frame on, frame off, length-1, polarity, mask |
| dat_we | input | 1 | Data write strobe; starts a transfer when idle |
| dat_wdata | input | 16 | Word to transmit, right-aligned |
| rx_word | output | 16 | Last received word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer strobe |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| frm | output | 1 | Frame strobe |

## Verification
The data write registers on the clock edge. From that edge on, base count k applies to system cycles k*D through k*D + D - 1. busy falls and done rises exactly (S + 2N) * D cycles later. The bench numbers every cycle from the write, samples at the falling edge, and derives the expected sck, sdo and frame levels of each cycle from that numbering. It checks rx_word and done in the first cycle in which busy is low, and it checks done again one cycle later.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam int CNT_W  = 8;
  localparam int WORD_W = 16;
  localparam int LEN_W  = $clog2(WORD_W);
  localparam int BC_W   = CNT_W + 2;

  typedef struct packed {
    logic [CNT_W-1:0] div;
    logic [CNT_W-1:0] dly;
    logic [CNT_W-1:0] fon;
    logic [CNT_W-1:0] foff;
    logic [LEN_W-1:0] len_m1;
    logic             act_hi;
    logic             mask_last;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/fsp_tick.sv
module fsp_tick
  import fsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [CNT_W-1:0] div,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim  = (div == '0) ? '0 : div - 1'b1;
    tick = run && (cnt_q == lim);
    if (restart)   cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (run)  cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div > 1) |=> !tick);
endmodule

// File: rtl/fsp_ctrl.sv
module fsp_ctrl
  import fsp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_we,
  input  cfg_t            ctl_in,
  input  logic            dat_we,
  input  logic            tick,
  output cfg_t            cfg,
  output logic            start,
  output logic            busy,
  output logic            done,
  output logic            fin,
  output logic [BC_W-1:0] bcnt
);
  cfg_t            cfg_d;
  logic            busy_d, done_d;
  logic [BC_W-1:0] bcnt_d, end_pt;

  always_comb begin
    start  = dat_we && !busy;
    end_pt = BC_W'(cfg.dly) + (BC_W'(cfg.len_m1) << 1) + 1'b1;
    fin    = busy && tick && (bcnt == end_pt);
    cfg_d  = (ctl_we && !busy) ? ctl_in : cfg;
    busy_d = busy;
    bcnt_d = bcnt;
    if (start) begin
      busy_d = 1'b1;
      bcnt_d = '0;
    end else if (fin) begin
      busy_d = 1'b0;
    end else if (busy && tick) begin
      bcnt_d = bcnt + 1'b1;
    end
    done_d = fin;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
      bcnt <= '0;
    end else begin
      cfg  <= cfg_d;
      busy <= busy_d;
      done <= done_d;
      bcnt <= bcnt_d;
    end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg));
endmodule

// File: rtl/fsp_shift.sv
module fsp_shift
  import fsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_in,
  input  logic              busy,
  input  logic              tick,
  input  logic              fin,
  input  logic [BC_W-1:0]   bcnt,
  input  cfg_t              cfg,
  input  logic              sdi,
  output logic              sdo,
  output logic              sck,
  output logic [WORD_W-1:0] rx_word
);
  logic [WORD_W-1:0] tx_q, tx_d, rx_q, rx_d, rxw_d;
  logic [BC_W-1:0]   rel;
  logic              in_shift, last;

  always_comb begin
    rel      = bcnt - BC_W'(cfg.dly);
    in_shift = busy && (bcnt >= BC_W'(cfg.dly));
    last     = (rel[BC_W-1:1] == (BC_W-1)'(cfg.len_m1));
    sdo      = in_shift && tx_q[WORD_W-1];
    sck      = in_shift && rel[0] && !(cfg.mask_last && last);
    tx_d     = tx_q;
    rx_d     = rx_q;
    if (start) begin
      tx_d = tx_in << (WORD_W - 1 - int'(cfg.len_m1));
      rx_d = '0;
    end else if (in_shift && tick) begin
      if (rel[0]) tx_d = {tx_q[WORD_W-2:0], 1'b0};
      else        rx_d = {rx_q[WORD_W-2:0], sdi};
    end
    rxw_d = fin ? rx_q : rx_word;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_q    <= '0;
      rx_q    <= '0;
      rx_word <= '0;
    end else begin
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      rx_word <= rxw_d;
    end

  p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  p_sdo_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(tick)) |-> $stable(sdo));
endmodule

// File: rtl/fsp_frame.sv
module fsp_frame
  import fsp_pkg::*;
(
  input  logic            busy,
  input  logic [BC_W-1:0] bcnt,
  input  cfg_t            cfg,
  output logic            frm
);
  logic active;

  always_comb begin
    active = busy && (bcnt >= BC_W'(cfg.fon)) && (bcnt < BC_W'(cfg.foff));
    frm    = cfg.act_hi ? active : !active;
  end
endmodule

// File: rtl/fsp_top.sv
module fsp_top
  import fsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CFG_W-1:0]  ctl_wdata,
  input  logic              dat_we,
  input  logic [WORD_W-1:0] dat_wdata,
  output logic [WORD_W-1:0] rx_word,
  output logic              busy,
  output logic              done,
  output logic              sdo,
  input  logic              sdi,
  output logic              sck,
  output logic              frm
);
  logic [1:0]      rs_q;
  logic            rst_s, tick, start, fin;
  logic [BC_W-1:0] bcnt;
  cfg_t            cfg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  assign rst_s = rs_q[1];

  fsp_tick u_tick (
    .clk(clk), .rst_n(rst_s), .restart(start), .run(busy),
    .div(cfg.div), .tick(tick));

  fsp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_s), .ctl_we(ctl_we), .ctl_in(cfg_t'(ctl_wdata)),
    .dat_we(dat_we), .tick(tick), .cfg(cfg), .start(start), .busy(busy),
    .done(done), .fin(fin), .bcnt(bcnt));

  fsp_shift u_shift (
    .clk(clk), .rst_n(rst_s), .start(start), .tx_in(dat_wdata), .busy(busy),
    .tick(tick), .fin(fin), .bcnt(bcnt), .cfg(cfg), .sdi(sdi), .sdo(sdo),
    .sck(sck), .rx_word(rx_word));

  fsp_frame u_frame (.busy(busy), .bcnt(bcnt), .cfg(cfg), .frm(frm));
endmodule

// File: tb/sim_fsp_top.sv
module sim_fsp_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0, dat_we = 1'b0;
  logic [37:0] ctl_wdata = '0;
  logic [15:0] dat_wdata = '0;
  logic [15:0] rx_word;
  logic        busy, done, sdo, sdi, sck, frm;
  logic        inv = 1'b0;
  int          checks = 0, errors = 0, cyc_all = 0;

  assign sdi = sdo ^ inv;
  always #4 clk = ~clk;

  fsp_top u0 (.*);

  typedef struct packed {
    logic [7:0] div, dly, fon, foff;
    logic [4:0] n;
    logic hi, msk, iv;
    logic [15:0] dat;
  } vec_t;

  localparam vec_t VT [6] = '{
    '{8'd1, 8'd0, 8'd0, 8'd40,  5'd8,  1'b0, 1'b0, 1'b0, 16'h00A5},
    '{8'd0, 8'd2, 8'd1, 8'd10,  5'd8,  1'b1, 1'b0, 1'b1, 16'h003C},
    '{8'd3, 8'd1, 8'd2, 8'd6,   5'd16, 1'b1, 1'b0, 1'b0, 16'hBEEF},
    '{8'd2, 8'd0, 8'd0, 8'd3,   5'd1,  1'b0, 1'b0, 1'b0, 16'h0001},
    '{8'd1, 8'd4, 8'd4, 8'd8,   5'd5,  1'b1, 1'b1, 1'b0, 16'h0013},
    '{8'd4, 8'd3, 8'd0, 8'd255, 5'd12, 1'b0, 1'b1, 1'b1, 16'h0ABC}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [37:0] cfgw(vec_t v);
    logic [3:0] lm = 4'(v.n - 5'd1);
    return {v.div, v.dly, v.fon, v.foff, lm, v.hi, v.msk};
  endfunction

  task automatic wr_cfg(input logic [37:0] w);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = w;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_dat(input logic [15:0] d);
    @(negedge clk); dat_we = 1'b1; dat_wdata = d;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int d, c, fact, pulses, nb, endk, exp_len, exp_f;
    logic [15:0] bits, msk;
    logic prev;
    d = (v.div == 0) ? 1 : int'(v.div);
    inv = v.iv;
    wr_cfg(cfgw(v));
    wr_dat(v.dat);
    c = 0; fact = 0; pulses = 0; nb = 0; bits = '0; prev = 1'b0;
    while (busy && c < 5000) begin
      if (frm == v.hi) fact++;
      if (sck && !prev) pulses++;
      prev = sck;
      if ((c % d) == 0 && (c / d) >= int'(v.dly) && (((c / d) - int'(v.dly)) % 2) == 0) begin
        bits = {bits[14:0], sdo};
        nb++;
      end
      @(negedge clk); c++;
    end
    endk = int'(v.dly) + 2 * int'(v.n);
    exp_len = endk * d;
    exp_f = 0;
    for (int k = int'(v.fon); k < int'(v.foff) && k < endk; k++) exp_f += d;
    msk = 16'((32'd1 << v.n) - 1);
    chk(c == exp_len, "R2/R3 busy length", c, exp_len);
    chk(done == 1'b1, "R2 done at end", done, 1);
    chk(rx_word == ((v.iv ? ~v.dat : v.dat) & msk), "R6/R7 rx_word",
        rx_word, (v.iv ? ~v.dat : v.dat) & msk);
    chk(bits == (v.dat & msk) && nb == int'(v.n), "R5/R7 sdo MSB first", bits, v.dat & msk);
    chk(pulses == int'(v.n) - int'(v.msk), "R4/R9 sck pulses", pulses, int'(v.n) - int'(v.msk));
    chk(fact == exp_f, "R8 frame window", fact, exp_f);
    chk(frm == !v.hi && sck == 1'b0, "R8/R4 idle levels", {frm, sck}, {!v.hi, 1'b0});
    @(negedge clk);
    chk(done == 1'b0, "R2 done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !sck && !sdo, "R1 reset outputs", {busy, done, sck, sdo}, 0);
    chk(frm == 1'b1 && rx_word == 16'h0, "R1 reset frame/rx", {frm, rx_word}, 17'h10000);

    for (int i = 0; i < 6; i++) run_vec(VT[i]);

    begin : r10_block
      int c;
      inv = 1'b0;
      wr_cfg({8'd1, 8'd0, 8'd0, 8'd0, 4'd3, 1'b1, 1'b0});
      wr_dat(16'h0009);
      ctl_we = 1'b1; ctl_wdata = {8'd5, 8'd6, 8'd0, 8'd0, 4'd15, 1'b0, 1'b0};
      dat_we = 1'b1; dat_wdata = 16'h000F;
      @(negedge clk); ctl_we = 1'b0; dat_we = 1'b0;
      c = 1;
      while (busy && c < 5000) begin @(negedge clk); c++; end
      chk(c == 8, "R10 ctl write while busy", c, 8);
      chk(rx_word == 16'h0009, "R10 data write while busy", rx_word, 16'h0009);
      chk(frm == 1'b0, "R10 polarity kept", frm, 0);
      wr_dat(16'h0006);
      c = 0;
      while (busy && c < 5000) begin @(negedge clk); c++; end
      chk(c == 8, "R10 old config retained", c, 8);
      chk(rx_word == 16'h0006, "R6 second word", rx_word, 16'h0006);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule